// File: doc/BRIEF.md
# Cartridge Bank-Switching Register Decoder

This block sits on the cartridge side of an 8-bit console. It watches CPU writes and, when a write lands inside the register window, stores the byte in a small register file: eight 1 KB character bank selects, one 16 KB program page select and a nametable mirroring mode. From those registers it forms, in pure logic, the extended program ROM address for the CPU, the extended character ROM address for the picture bus, and the nametable select line that picks one of the two console-side nametable RAM halves.

A two-bit variant input chooses which CPU address window reaches the registers: the low window $6000-$7FFF, the high window $8000-$FFFF, or both. Writes to offsets 0xA, 0xB and 0xC are not stored here. They leave the block as one-cycle strobes with the write data and a flag that says which window they came from, so that an external interrupt counter can apply either its latched (high window) or its direct (low window) behaviour. Every write in $6000-$7FFF is also passed out as a work-RAM write enable.

Top module: `cart_bank_decoder`

## Requirements
- R1: A register write to offset 0x0..0x7 (cpu_addr[3:0]) stores the full data byte in the character bank register whose index is that offset.
- R2: A register write to offset 0x8 stores cpu_data[3:0] as the program page; CPU addresses $8000-$BFFF map to prg_addr = {page, cpu_addr[13:0]}.
- R3: CPU addresses $C000-$FFFF always map to prg_addr = {4'hF, cpu_addr[13:0]}, the last 16 KB page of a 256 KB program ROM.
- R4: A register write to offset 0x9 sets the mirroring mode from cpu_data[1:0]; nt_sel is ppu_addr[10] for mode 0 (vertical), ppu_addr[11] for mode 1 (horizontal), 0 for mode 2 (single-screen lower) and 1 for mode 3 (single-screen upper).
- R5: A write is a register write only inside the window set by variant: 2'd1 accepts $6000-$7FFF only, 2'd2 accepts $8000-$FFFF only, 2'd0 and 2'd3 accept both; writes outside the window change no register.
- R6: wram_we is high in the same cycle as any CPU write in $6000-$7FFF, whatever the variant and offset, and low otherwise.
- R7: chr_addr = {bank[ppu_addr[12:10]], ppu_addr[9:0]}, where bank[n] is character bank register n.
- R8: A register write to offset 0xA, 0xB or 0xC raises irq_ctrl_wr, irq_lo_wr or irq_hi_wr respectively in that cycle, with irq_wr_data equal to cpu_data and irq_high_range equal to cpu_addr[15]; no strobe is raised for any other write.
- R9: After reset every bank register is 0 and the mirroring mode is vertical.
- R10: Register writes to offsets 0xD..0xF change no register and raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CPU bus rate |
| rst_n | input | 1 | Synchronous reset, active low |
| variant | input | 2 | Register window select (see R5) |
| cpu_wr | input | 1 | CPU write qualifier for this cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | Picture-bus address, pattern space |
| prg_addr | output | 18 | Program ROM address |
| chr_addr | output | 18 | Character ROM address |
| nt_sel | output | 1 | Nametable RAM half select |
| wram_we | output | 1 | Work-RAM write enable for $6000-$7FFF |
| irq_ctrl_wr | output | 1 | Strobe, write to offset 0xA |
| irq_lo_wr | output | 1 | Strobe, write to offset 0xB |
| irq_hi_wr | output | 1 | Strobe, write to offset 0xC |
| irq_wr_data | output | 8 | Data that goes with a strobe |
| irq_high_range | output | 1 | Strobe came from the $8000 window |

## Verification
A wrong bank register is invisible until the matching address is presented: a bad character bank shows only when ppu_addr[12:10] selects that slot, and a bad program page only for a CPU fetch in $8000-$BFFF, so the bench sweeps all eight slots and both program halves after writes. Register errors appear on the cycle after the offending write, while window and strobe decode errors appear combinationally in the write cycle itself. A wrong mirroring state is exposed by toggling ppu_addr[11:10] through all four combinations.

// File: rtl/cart_bank_decoder.sv
module cart_bank_decoder #(
  parameter int DATA_W     = 8,
  parameter int PRG_BANK_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 variant,
  input  logic                       cpu_wr,
  input  logic [15:0]                cpu_addr,
  input  logic [DATA_W-1:0]          cpu_data,
  input  logic [12:0]                ppu_addr,
  output logic [PRG_BANK_W+13:0]     prg_addr,
  output logic [DATA_W+9:0]          chr_addr,
  output logic                       nt_sel,
  output logic                       wram_we,
  output logic                       irq_ctrl_wr,
  output logic                       irq_lo_wr,
  output logic                       irq_hi_wr,
  output logic [DATA_W-1:0]          irq_wr_data,
  output logic                       irq_high_range
);

  localparam int SLOTS = 8;

  typedef enum logic [1:0] {MIR_VERT, MIR_HORZ, MIR_LOW, MIR_HIGH} mir_t;

  logic                  in_low, in_high, in_win, reg_hit;
  logic [3:0]            off;
  logic [DATA_W-1:0]     chr_bank [SLOTS];
  logic [PRG_BANK_W-1:0] prg_bank;
  logic [PRG_BANK_W-1:0] prg_page;
  mir_t                  mir;

  assign in_low  = (cpu_addr[15:13] == 3'b011);
  assign in_high = cpu_addr[15];
  assign off     = cpu_addr[3:0];

  always_comb begin
    case (variant)
      2'd1:    in_win = in_low;
      2'd2:    in_win = in_high;
      default: in_win = in_low | in_high;
    endcase
  end

  assign reg_hit = cpu_wr & in_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) chr_bank[i] <= '0;
      prg_bank <= '0;
      mir      <= MIR_VERT;
    end else if (reg_hit) begin
      if (!off[3])
        chr_bank[off[2:0]] <= cpu_data;
      else if (off == 4'h8)
        prg_bank <= cpu_data[PRG_BANK_W-1:0];
      else if (off == 4'h9)
        mir <= mir_t'(cpu_data[1:0]);
    end
  end

  assign prg_page = cpu_addr[14] ? '1 : prg_bank;
  assign prg_addr = {prg_page, cpu_addr[13:0]};
  assign chr_addr = {chr_bank[ppu_addr[12:10]], ppu_addr[9:0]};

  always_comb begin
    case (mir)
      MIR_VERT: nt_sel = ppu_addr[10];
      MIR_HORZ: nt_sel = ppu_addr[11];
      MIR_LOW:  nt_sel = 1'b0;
      default:  nt_sel = 1'b1;
    endcase
  end

  assign wram_we        = cpu_wr & in_low;
  assign irq_ctrl_wr    = reg_hit & (off == 4'hA);
  assign irq_lo_wr      = reg_hit & (off == 4'hB);
  assign irq_hi_wr      = reg_hit & (off == 4'hC);
  assign irq_wr_data    = cpu_data;
  assign irq_high_range = in_high;

endmodule

// File: rtl/cart_bank_decoder_chk.sv
module cart_bank_decoder_chk #(
  parameter int DATA_W     = 8,
  parameter int PRG_BANK_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cpu_wr,
  input logic [15:0]            cpu_addr,
  input logic [DATA_W-1:0]      cpu_data,
  input logic                   reg_hit,
  input logic [PRG_BANK_W-1:0]  prg_bank,
  input logic [1:0]             mir,
  input logic [PRG_BANK_W+13:0] prg_addr,
  input logic                   nt_sel,
  input logic                   wram_we,
  input logic                   irq_ctrl_wr,
  input logic                   irq_lo_wr,
  input logic                   irq_hi_wr
);

  p_prg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_hit && cpu_addr[3:0] == 4'h8) |=> prg_bank == $past(cpu_data[PRG_BANK_W-1:0]));

  p_prg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_hit && cpu_addr[3:0] == 4'h8) |=> $stable(prg_bank));

  p_mir_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_hit && cpu_addr[3:0] == 4'h9) |=> $stable(mir));

  p_top_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'b11) |-> (&prg_addr[PRG_BANK_W+13:14]));

  p_single_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mir == 2'd3) |-> nt_sel);

  p_wram_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wram_we |-> (cpu_wr && cpu_addr[15:13] == 3'b011));

  p_strobe_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_ctrl_wr, irq_lo_wr, irq_hi_wr}));

  p_strobe_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ctrl_wr || irq_lo_wr || irq_hi_wr) |-> reg_hit);

endmodule

bind cart_bank_decoder cart_bank_decoder_chk #(.DATA_W(DATA_W), .PRG_BANK_W(PRG_BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
  .reg_hit(reg_hit), .prg_bank(prg_bank), .mir(mir), .prg_addr(prg_addr), .nt_sel(nt_sel),
  .wram_we(wram_we), .irq_ctrl_wr(irq_ctrl_wr), .irq_lo_wr(irq_lo_wr), .irq_hi_wr(irq_hi_wr)
);

// File: tb/cart_bank_decoder_tb.sv
`timescale 1ns/1ps
module cart_bank_decoder_tb;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [1:0]  variant = 0;
  logic        cpu_wr = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_data = 0;
  logic [12:0] ppu_addr = 0;
  logic [17:0] prg_addr, chr_addr;
  logic        nt_sel, wram_we, irq_ctrl_wr, irq_lo_wr, irq_hi_wr, irq_high_range;
  logic [7:0]  irq_wr_data;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_chr [8];
  logic [3:0] m_prg;
  logic [1:0] m_mir;

  always #4 clk = ~clk;

  cart_bank_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .variant(variant), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .ppu_addr(ppu_addr), .prg_addr(prg_addr), .chr_addr(chr_addr),
    .nt_sel(nt_sel), .wram_we(wram_we), .irq_ctrl_wr(irq_ctrl_wr), .irq_lo_wr(irq_lo_wr),
    .irq_hi_wr(irq_hi_wr), .irq_wr_data(irq_wr_data), .irq_high_range(irq_high_range)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic win(input logic [1:0] v, input logic [15:0] a);
    logic lo = (a[15:13] == 3'b011);
    case (v)
      2'd1:    return lo;
      2'd2:    return a[15];
      default: return lo | a[15];
    endcase
  endfunction

  function automatic logic exp_nt(input logic [1:0] m, input logic [12:0] p);
    case (m)
      2'd0:    return p[10];
      2'd1:    return p[11];
      2'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) m_chr[i] = 8'h00;
    m_prg = 4'h0;
    m_mir = 2'd0;
  endtask

  // Called just after a falling edge; returns just after the next one.
  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    logic hit = win(variant, a);
    logic [3:0] o = a[3:0];
    cpu_wr = 1; cpu_addr = a; cpu_data = d;
    #1;
    chk("R6 wram_we", wram_we, a[15:13] == 3'b011);
    chk("R8 ctrl strobe", irq_ctrl_wr, hit && o == 4'hA);
    chk("R8 lo strobe", irq_lo_wr, hit && o == 4'hB);
    chk("R8 hi strobe", irq_hi_wr, hit && o == 4'hC);
    if (irq_ctrl_wr || irq_lo_wr || irq_hi_wr) begin
      chk("R8 strobe data", irq_wr_data, d);
      chk("R8 range flag", irq_high_range, a[15]);
    end
    @(posedge clk); #1;
    cpu_wr = 0;
    if (hit) begin
      if (o < 8) m_chr[o[2:0]] = d;
      else if (o == 4'h8) m_prg = d[3:0];
      else if (o == 4'h9) m_mir = d[1:0];
    end
    @(negedge clk);
  endtask

  task automatic probe_all(input string tag);
    for (int s = 0; s < 8; s++) begin
      logic [9:0] lo = 10'($urandom);
      ppu_addr = {s[2:0], lo};
      #1;
      chk({tag, " R7 chr slot"}, chr_addr, {m_chr[s], lo});
    end
    begin
      logic [13:0] lo = 14'($urandom);
      cpu_addr = {2'b10, lo}; #1;
      chk({tag, " R2 prg low half"}, prg_addr, {m_prg, lo});
      cpu_addr = {2'b11, lo}; #1;
      chk({tag, " R3 prg fixed half"}, prg_addr, {4'hF, lo});
    end
    for (int k = 0; k < 4; k++) begin
      ppu_addr = {1'b0, k[1:0], 10'($urandom)}; #1;
      chk({tag, " R4 nt_sel"}, nt_sel, exp_nt(m_mir, ppu_addr));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    probe_all("R9 reset");

    // R1 / R7: fill each slot in the high window, variant both
    variant = 2'd0;
    for (int i = 0; i < 8; i++) do_write(16'h8000 | 16'(i), 8'h11 * 8'(i + 1) ^ 8'hA5);
    probe_all("R1 fill");

    // R2: upper data bits dropped
    do_write(16'h9FF8, 8'hF6);
    probe_all("R2 load");

    // R4: each mirroring mode
    for (int m = 0; m < 4; m++) begin
      do_write(16'h7009, {6'h3F, m[1:0]});
      probe_all("R4 mode");
    end

    // R5: window per variant
    variant = 2'd1;
    do_write(16'h8008, 8'h03);
    probe_all("R5 high ignored in low-only");
    do_write(16'h6008, 8'h05);
    probe_all("R5 low accepted");
    variant = 2'd2;
    do_write(16'h6008, 8'h09);
    probe_all("R5 low ignored in high-only");
    do_write(16'hE008, 8'h0C);
    probe_all("R5 high accepted");
    variant = 2'd3;
    do_write(16'h4008, 8'h02);
    probe_all("R5 below windows ignored");

    // R10: offsets D..F
    for (int o = 13; o < 16; o++) do_write(16'h8000 | 16'(o), 8'hFF);
    probe_all("R10 ignored offsets");

    // R8: strobes from each window
    variant = 2'd0;
    do_write(16'h800A, 8'h01);
    do_write(16'h600B, 8'h34);
    do_write(16'hF00C, 8'h12);
    variant = 2'd2;
    do_write(16'h600A, 8'h01);
    probe_all("R8 strobe no state");

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [15:0] a;
      variant = 2'($urandom);
      case ($urandom % 3)
        0:       a = {3'b010, 13'($urandom)};
        1:       a = {3'b011, 13'($urandom)};
        default: a = {1'b1, 15'($urandom)};
      endcase
      do_write(a, 8'($urandom));
      if (n % 20 == 19) probe_all("R5 random");
    end

    // Reset again mid-run (R9)
    rst_n = 0;
    @(posedge clk); #1;
    rst_n = 1;
    model_reset();
    @(negedge clk);
    probe_all("R9 re-reset");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule